// File: doc/BRIEF.md
# Synchronous Shift-Register Serial Port

This block is the half-duplex synchronous shift mode of a byte-wide serial port. One bidirectional data line carries eight bits per transfer, least-significant bit first, and the block drives the shift clock on a second line. The bench-facing clock `clk_i` is the oscillator. Each bit slot lasts twelve oscillator periods, and the shift clock is derived from that slot count.

Software starts a transmit by writing a byte into the transmit buffer. It starts a receive by raising the start request while the receive enable is set. When the eighth bit has moved, a done flag for that direction is raised. The flag stays up until its clear input is pulsed. The pin driver is modelled as an output value plus an output enable.

Within a slot, the data line changes at phase 0. The shift clock is high in phases 0–3, low in phases 4–9 and high again in phases 10–11. The rising edge therefore comes ten oscillator periods after the data change, and the data holds for two periods after that edge. A receive samples the data line on the oscillator edge that raises the shift clock.

Top module: `ssp_sync_serial`

## Requirements
- R1: After reset the shift clock is high, the data output enable is low, both done flags are 0 and the received byte is 0x00.
- R2: A transmit-buffer write accepted while idle drives the byte on `sd_o` with `sd_oe_o` high. Bits go out LSB first, bit k for the 12 cycles k*12 .. k*12+11 after the write edge, 96 cycles in all.
- R3: During a transfer, `sclk_o` is low in slot phases 4 to 9 and high in phases 0 to 3 and 10 to 11. The rise therefore comes 10 oscillator cycles after the data change.
- R4: Transmit data stays stable for the whole slot, including the 2 cycles after the shift-clock rise. It changes only at slot phase 0.
- R5: In a receive, `sd_i` is sampled on the edge that raises `sclk_o`. The samples are assembled LSB first, and `rx_data_o` shows the byte when `rx_done_o` rises. A change of `sd_i` right after that edge does not affect the result.
- R6: A receive starts only if `rx_en_i` and `rx_start_i` are both high and `rx_done_o` is low. Otherwise the request is dropped: `sclk_o` stays high and `rx_data_o` is unchanged.
- R7: The done flag of a direction sets on the cycle the transfer ends (96 cycles after start). It then stays set until its clear input is high.
- R8: Between transfers `sclk_o` is high and `sd_oe_o` is low. During a receive, `sd_oe_o` stays low.
- R9: A transmit write or receive request arriving during a transfer is ignored, and the running transfer continues unchanged.
- R10: If a transmit write and a valid receive request arrive in the same idle cycle, the transmit is started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tx_wr_i | input | 1 | Transmit-buffer write strobe |
| tx_data_i | input | 8 | Byte to transmit |
| rx_en_i | input | 1 | Receive enable |
| rx_start_i | input | 1 | Receive start request |
| tx_done_clr_i | input | 1 | Clears the transmit-done flag |
| rx_done_clr_i | input | 1 | Clears the receive-done flag |
| sd_i | input | 1 | Serial data line, input side |
| sd_o | output | 1 | Serial data line, output value |
| sd_oe_o | output | 1 | Serial data line, output enable |
| sclk_o | output | 1 | Shift clock |
| tx_done_o | output | 1 | Transmit-done flag |
| rx_done_o | output | 1 | Receive-done flag |
| rx_data_o | output | 8 | Last received byte |

## Verification
Transmits are run with random bytes plus 0x00, 0xFF and alternating patterns. Each cycle of the 96-cycle window is compared against the expected bit and clock phase, so a wrong bit order, slot length or clock phase shows up. Receives drive each bit at the falling edge of the shift clock and overwrite the line right after the rise. This distinguishes sampling at the rise from sampling in any other phase. Directed cases cover writes during a transfer, requests with the enable low or the done flag set, simultaneous transmit and receive requests, and flag persistence until clear.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  typedef enum logic [1:0] {
    DIR_IDLE = 2'd0,
    DIR_TX   = 2'd1,
    DIR_RX   = 2'd2
  } dir_e;
endpackage

// File: rtl/ssp_timing.sv
module ssp_timing #(
  parameter int DIV   = 12,
  parameter int HOLD  = 2,
  parameter int NBITS = 8,
  localparam int PH_W   = $clog2(DIV),
  localparam int BIT_W  = $clog2(NBITS),
  localparam int RISE_PH = DIV - HOLD,
  localparam int FALL_PH = RISE_PH - DIV / 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            run_i,
  output logic [PH_W-1:0] phase_o,
  output logic            sample_o,
  output logic            shift_o,
  output logic            last_o,
  output logic            sclk_o
);
  logic [PH_W-1:0]  phase_q, phase_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic             sclk_q, sclk_d, run_d;
  logic             slot_end;

  assign slot_end = run_i && (phase_q == PH_W'(DIV - 1));
  assign last_o   = slot_end && (bit_q == BIT_W'(NBITS - 1));
  assign shift_o  = slot_end && !last_o;
  assign sample_o = run_i && (phase_q == PH_W'(RISE_PH - 1));

  always_comb begin
    phase_d = phase_q;
    bit_d   = bit_q;
    if (start_i) begin
      phase_d = '0;
      bit_d   = '0;
    end else if (run_i) begin
      if (slot_end) begin
        phase_d = '0;
        bit_d   = bit_q + 1'b1;
      end else begin
        phase_d = phase_q + 1'b1;
      end
    end
    run_d  = start_i || (run_i && !last_o);
    // low window sits so the rise lands HOLD cycles before slot end
    sclk_d = !(run_d && (phase_d >= PH_W'(FALL_PH)) && (phase_d < PH_W'(RISE_PH)));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      bit_q   <= '0;
      sclk_q  <= 1'b1;
    end else begin
      phase_q <= phase_d;
      bit_q   <= bit_d;
      sclk_q  <= sclk_d;
    end
  end

  assign phase_o = phase_q;
  assign sclk_o  = sclk_q;

  AST_PHASE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q < PH_W'(DIV)); // R2
  AST_SAMPLE_AT_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_o && !start_i) |=> $rose(sclk_o)); // R5
endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter #(
  parameter int NBITS = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [NBITS-1:0] load_data_i,
  input  logic             tx_shift_i,
  input  logic             rx_sample_i,
  input  logic             sd_i,
  output logic [NBITS-1:0] data_o,
  output logic             lsb_o
);
  logic [NBITS-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q <= '1;
    end else if (load_i) begin
      sr_q <= load_data_i;
    end else if (tx_shift_i) begin
      sr_q <= {1'b1, sr_q[NBITS-1:1]};
    end else if (rx_sample_i) begin
      sr_q <= {sd_i, sr_q[NBITS-1:1]};
    end
  end

  assign data_o = sr_q;
  assign lsb_o  = sr_q[0];
endmodule

// File: rtl/ssp_ctrl.sv
module ssp_ctrl
  import ssp_pkg::*;
#(
  parameter int NBITS = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tx_wr_i,
  input  logic             rx_en_i,
  input  logic             rx_start_i,
  input  logic             tx_done_clr_i,
  input  logic             rx_done_clr_i,
  input  logic             last_i,
  input  logic [NBITS-1:0] shift_data_i,
  output logic             start_o,
  output logic             start_tx_o,
  output dir_e             dir_o,
  output logic             tx_done_o,
  output logic             rx_done_o,
  output logic [NBITS-1:0] rx_data_o
);
  dir_e             dir_q;
  logic             tx_done_q, rx_done_q;
  logic [NBITS-1:0] rx_data_q;
  logic             idle, start_tx, start_rx;

  assign idle     = (dir_q == DIR_IDLE);
  assign start_tx = idle && tx_wr_i;
  assign start_rx = idle && !tx_wr_i && rx_en_i && rx_start_i && !rx_done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q     <= DIR_IDLE;
      tx_done_q <= 1'b0;
      rx_done_q <= 1'b0;
      rx_data_q <= '0;
    end else begin
      if (start_tx)      dir_q <= DIR_TX;
      else if (start_rx) dir_q <= DIR_RX;
      else if (last_i)   dir_q <= DIR_IDLE;

      if (last_i && dir_q == DIR_TX) tx_done_q <= 1'b1;
      else if (tx_done_clr_i)        tx_done_q <= 1'b0;

      if (last_i && dir_q == DIR_RX) begin
        rx_done_q <= 1'b1;
        rx_data_q <= shift_data_i;
      end else if (rx_done_clr_i) begin
        rx_done_q <= 1'b0;
      end
    end
  end

  assign start_o    = start_tx || start_rx;
  assign start_tx_o = start_tx;
  assign dir_o      = dir_q;
  assign tx_done_o  = tx_done_q;
  assign rx_done_o  = rx_done_q;
  assign rx_data_o  = rx_data_q;

  AST_RX_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && rx_done_q) |=> (dir_q != DIR_RX)); // R6
  AST_BUSY_IGNORES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_q == DIR_TX && !last_i) |=> (dir_q == DIR_TX)); // R9
  AST_TX_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && tx_wr_i) |=> (dir_q == DIR_TX)); // R10
  AST_TX_DONE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_done_q && !tx_done_clr_i) |=> tx_done_q); // R7
endmodule

// File: rtl/ssp_sync_serial.sv
module ssp_sync_serial
  import ssp_pkg::*;
#(
  parameter int DIV   = 12,
  parameter int HOLD  = 2,
  parameter int NBITS = 8,
  localparam int PH_W = $clog2(DIV)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tx_wr_i,
  input  logic [NBITS-1:0] tx_data_i,
  input  logic             rx_en_i,
  input  logic             rx_start_i,
  input  logic             tx_done_clr_i,
  input  logic             rx_done_clr_i,
  input  logic             sd_i,
  output logic             sd_o,
  output logic             sd_oe_o,
  output logic             sclk_o,
  output logic             tx_done_o,
  output logic             rx_done_o,
  output logic [NBITS-1:0] rx_data_o
);
  dir_e             dir;
  logic             start, start_tx, run;
  logic             sample, shift, last;
  logic [PH_W-1:0]  phase;
  logic [NBITS-1:0] sr_data;
  logic             sr_lsb;

  assign run = (dir != DIR_IDLE);

  ssp_ctrl #(.NBITS(NBITS)) u_ctrl (
    .clk_i, .rst_ni, .tx_wr_i, .rx_en_i, .rx_start_i,
    .tx_done_clr_i, .rx_done_clr_i,
    .last_i       (last),
    .shift_data_i (sr_data),
    .start_o      (start),
    .start_tx_o   (start_tx),
    .dir_o        (dir),
    .tx_done_o, .rx_done_o, .rx_data_o
  );

  ssp_timing #(.DIV(DIV), .HOLD(HOLD), .NBITS(NBITS)) u_timing (
    .clk_i, .rst_ni,
    .start_i  (start),
    .run_i    (run),
    .phase_o  (phase),
    .sample_o (sample),
    .shift_o  (shift),
    .last_o   (last),
    .sclk_o
  );

  ssp_shifter #(.NBITS(NBITS)) u_shift (
    .clk_i, .rst_ni,
    .load_i      (start),
    .load_data_i (start_tx ? tx_data_i : {NBITS{1'b1}}),
    .tx_shift_i  (shift && dir == DIR_TX),
    .rx_sample_i (sample && dir == DIR_RX),
    .sd_i,
    .data_o      (sr_data),
    .lsb_o       (sr_lsb)
  );

  assign sd_oe_o = (dir == DIR_TX);
  assign sd_o    = sd_oe_o ? sr_lsb : 1'b1;

  AST_SCLK_IDLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && !$past(run)) |-> sclk_o); // R8
  AST_NO_DRIVE_IN_RX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir == DIR_RX) |-> !sd_oe_o); // R8
  AST_TX_DATA_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir == DIR_TX && phase != PH_W'(DIV - 1)) |=> $stable(sd_o)); // R4
  AST_DONE_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sd_oe_o) |-> tx_done_o); // R7
endmodule

// File: tb/sim_ssp_sync_serial.sv
`timescale 1ns/1ps
module sim_ssp_sync_serial;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_wr = 1'b0, rx_en = 1'b0, rx_start = 1'b0;
  logic       tx_clr = 1'b0, rx_clr = 1'b0, sd_in = 1'b1;
  logic [7:0] tx_data = 8'h00;
  logic       sd_out, sd_oe, sclk, tx_done, rx_done;
  logic [7:0] rx_data;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  ssp_sync_serial u0 (
    .clk_i(clk), .rst_ni(rst_n), .tx_wr_i(tx_wr), .tx_data_i(tx_data),
    .rx_en_i(rx_en), .rx_start_i(rx_start), .tx_done_clr_i(tx_clr),
    .rx_done_clr_i(rx_clr), .sd_i(sd_in), .sd_o(sd_out), .sd_oe_o(sd_oe),
    .sclk_o(sclk), .tx_done_o(tx_done), .rx_done_o(rx_done), .rx_data_o(rx_data)
  );

  function automatic logic exp_sclk(int c);
    int ph = c % 12;
    return !(ph >= 4 && ph <= 9);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // R2 R3 R4 R9 R10: full transmit window check
  task automatic run_tx(input logic [7:0] d, input bit poke, input bit with_rx, input string req);
    int bad = 0;
    logic [31:0] a = 0, e = 0;
    @(negedge clk);
    tx_data = d; tx_wr = 1'b1;
    if (with_rx) begin rx_en = 1'b1; rx_start = 1'b1; end
    for (int c = 0; c < 96; c++) begin
      @(negedge clk);
      tx_wr = 1'b0; rx_start = 1'b0;
      if (poke && c == 20) begin tx_wr = 1'b1; tx_data = ~d; rx_en = 1'b1; rx_start = 1'b1; end
      if (sclk !== exp_sclk(c) || sd_oe !== 1'b1 || sd_out !== d[c/12]) begin
        if (bad == 0) begin a = {c[15:0], 5'b0, sclk, sd_oe, sd_out}; e = {c[15:0], 5'b0, exp_sclk(c), 1'b1, d[c/12]}; end
        bad++;
      end
    end
    chk(bad == 0, req, a, e);
    @(negedge clk);
    tx_data = 8'h00; rx_en = 1'b0;
    chk(tx_done === 1'b1 && sd_oe === 1'b0 && sclk === 1'b1, "R7 tx done at end",
        {tx_done, sd_oe, sclk}, 3'b101);
    if (with_rx) chk(rx_done === 1'b0, "R10 rx not run", rx_done, 0);
    repeat (5) @(negedge clk);
    chk(tx_done === 1'b1, "R7 tx done sticky", tx_done, 1);
    tx_clr = 1'b1; @(negedge clk); tx_clr = 1'b0;
    chk(tx_done === 1'b0, "R7 tx done cleared", tx_done, 0);
  endtask

  // R5 R3 R8: receive with line changed right after each sample edge
  task automatic run_rx(input logic [7:0] d);
    int bad = 0;
    logic [31:0] a = 0, e = 0;
    @(negedge clk);
    rx_en = 1'b1; rx_start = 1'b1;
    for (int c = 0; c < 96; c++) begin
      @(negedge clk);
      rx_start = 1'b0;
      if (sclk !== exp_sclk(c) || sd_oe !== 1'b0) begin
        if (bad == 0) begin a = {c[15:0], 6'b0, sclk, sd_oe}; e = {c[15:0], 6'b0, exp_sclk(c), 1'b0}; end
        bad++;
      end
      if (c % 12 == 4)  sd_in = d[c/12];
      if (c % 12 == 10) sd_in = ~d[c/12];
    end
    chk(bad == 0, "R3 R8 rx clock / no drive", a, e);
    @(negedge clk);
    chk(rx_done === 1'b1 && rx_data === d, "R5 rx byte", {rx_done, rx_data}, {1'b1, d});
    repeat (4) @(negedge clk);
    chk(rx_done === 1'b1, "R7 rx done sticky", rx_done, 1);
  endtask

  task automatic rx_clear();
    rx_clr = 1'b1; @(negedge clk); rx_clr = 1'b0;
  endtask

  // R6: request that must be dropped
  task automatic rx_dropped(input logic [7:0] keep, input string req);
    int bad = 0;
    @(negedge clk);
    rx_start = 1'b1;
    for (int c = 0; c < 30; c++) begin
      @(negedge clk);
      rx_start = 1'b0;
      sd_in = c[0];
      if (sclk !== 1'b1) bad++;
    end
    chk(bad == 0 && rx_data === keep, req, {bad[15:0], rx_data}, {16'h0, keep});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [7:0] prev;
    int unsigned s = $urandom(32'h1c0ffee);
    s = s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sclk === 1'b1 && sd_oe === 1'b0 && tx_done === 1'b0 && rx_done === 1'b0 && rx_data === 8'h00,
        "R1 reset state", {sclk, sd_oe, tx_done, rx_done, rx_data}, {4'b1000, 8'h00});

    run_tx(8'h00, 1'b0, 1'b0, "R2 tx 00");
    run_tx(8'hFF, 1'b0, 1'b0, "R2 tx FF");
    run_tx(8'hA5, 1'b0, 1'b0, "R3 R4 tx A5");
    run_tx(8'h3C, 1'b1, 1'b0, "R9 tx with writes during transfer");
    run_tx(8'h81, 1'b0, 1'b1, "R10 tx wins over rx");
    for (int i = 0; i < 5; i++) run_tx(8'($urandom), 1'b0, 1'b0, "R2 tx random");

    run_rx(8'h5A);
    prev = rx_data;
    rx_dropped(prev, "R6 rx blocked while done set");
    rx_clear();
    chk(rx_done === 1'b0, "R7 rx done cleared", rx_done, 0);
    rx_en = 1'b0;
    rx_dropped(prev, "R6 rx blocked while disabled");
    run_rx(8'h01); rx_clear();
    run_rx(8'h80); rx_clear();
    for (int i = 0; i < 5; i++) begin run_rx(8'($urandom)); rx_clear(); end

    summary();
  end
endmodule